// File: doc/BRIEF.md
# Square-Wave Quadrature Phase Selector

This block produces a digital four-phase keyed carrier from one master clock. A two-stage twisted-ring counter divides the master clock by four and exposes four logic-level square waves, each lagging the previous one by a quarter of the carrier period (0, 90, 180 and 270 degrees). A three-bit pseudo-random data register built from D flip-flops advances once per carrier period, at the rising edge of the first counter tap. Its two low bits are captured into a select register, and that register routes one of the four carrier phases to the output.

The carrier stays a square wave; shaping it into a sinusoid is left to whatever follows the block. An enable input acts as a clock enable for the whole block: while it is low, the counter, the data register and the select register all hold their state. The first counter tap is also brought out as the data clock, so that the symbols can be observed alongside the carrier.

Top module: `qpsk_phase_sel`

## Requirements
- R1: While `rst_n` is low, and just after it is released, `phase_o` is 4'b1100 (taps 0 and 1 low, taps 2 and 3 high), `sel_o` is 2'b00, `carrier_o` is 0 and `dclk_o` is 0.
- R2: After n enabled clock edges counted from reset, tap 0 (`phase_o[0]`) is 1 when n mod 4 is 1 or 2, and 0 when n mod 4 is 0 or 3. It is therefore a square wave with a period of four master clock cycles.
- R3: On every enabled edge, `phase_o[k]` takes the value that `phase_o[k-1]` had before the edge, for k = 1, 2 and 3. Each tap therefore lags the previous one by one master cycle, which is 90 degrees of carrier.
- R4: `dclk_o` always equals tap 0. The data register advances only on an enabled edge at which tap 0 rises.
- R5: The data register is 3 bits wide and is seeded with 3'b001 by reset. On each step its next value is {d[1:0], d[2] XOR d[1]}, which gives the 7-state sequence 001, 010, 101, 011, 111, 110, 100. It never holds zero.
- R6: On each data step, `sel_o` loads the low two bits of the data register as they were before that step (`sel_o[1]` = d[1], `sel_o[0]` = d[0]). After reset, the select values for data steps 1 to 7 are 01, 10, 01, 11, 11, 10, 00, and the sequence then repeats.
- R7: `carrier_o` is tap 0 (+sine) when `sel_o` is 00, tap 2 (−sine) when it is 01, tap 3 (+cosine, a quarter period ahead of sine) when it is 10, and tap 1 (−cosine) when it is 11.
- R8: While `en` is low, `phase_o`, `sel_o`, `dclk_o`, `carrier_o` and the data register keep their values, and no data step takes place even when a tap-0 rise is due.
- R9: `sel_o` changes only on an edge at which `dclk_o` rises, so the carrier phase switches only at the start of a data period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| en | input | 1 | Clock enable for the counter, data register and select register |
| carrier_o | output | 1 | Selected carrier phase |
| phase_o | output | 4 | Four square-wave carrier taps, a quarter period apart |
| sel_o | output | 2 | Registered phase-select code |
| dclk_o | output | 1 | Data clock (tap 0) |

## Verification
The assertions assume that `rst_n` is released away from the active clock edge and that `en` is a clean level that is sampled only at rising clock edges. The bench meets these assumptions by changing `rst_n` and `en` only on falling edges. The freeze property also assumes that nothing but `en` can stall the block. The stimulus therefore deasserts `en` exactly when a tap-0 rise is due and holds it low for longer than a carrier period, so that a missed hold or a spurious data step shows up at the outputs.

// File: rtl/qps_pkg.sv
package qps_pkg;
  localparam int RING_STAGES = 2;
  localparam int NUM_PHASES  = 2 * RING_STAGES;
  localparam int DATA_W      = 3;
  localparam int SEL_W       = 2;
  localparam logic [DATA_W-1:0] DATA_TAPS = 3'b110;
  localparam logic [DATA_W-1:0] DATA_SEED = 3'b001;

  typedef enum logic [SEL_W-1:0] {
    SYM_PSIN = 2'b00,
    SYM_NSIN = 2'b01,
    SYM_PCOS = 2'b10,
    SYM_NCOS = 2'b11
  } sym_e;

  // Tap index (lag in quarter periods) for each symbol
  function automatic logic [1:0] tap_of(input logic [SEL_W-1:0] code);
    case (sym_e'(code))
      SYM_PSIN: tap_of = 2'd0;
      SYM_NSIN: tap_of = 2'd2;
      SYM_PCOS: tap_of = 2'd3;
      default:  tap_of = 2'd1;
    endcase
  endfunction
endpackage

// File: rtl/qps_twist_ring.sv
module qps_twist_ring #(
  parameter int STAGES = 2,
  localparam int TAPS  = 2 * STAGES
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  output logic [TAPS-1:0] taps_o,
  output logic            rise_o
);
  logic [STAGES-1:0] q_r;
  logic [STAGES-1:0] q_nxt;

  always_comb begin
    q_nxt = q_r;
    if (en) q_nxt = {q_r[STAGES-2:0], ~q_r[STAGES-1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_nxt;
  end

  for (genvar k = 0; k < STAGES; k++) begin : g_tap
    assign taps_o[k]          = q_r[k];
    assign taps_o[k + STAGES] = ~q_r[k];
  end

  // Tap 0 goes high on this edge
  assign rise_o = en & ~q_r[0] & ~q_r[STAGES-1];
endmodule

// File: rtl/qps_lfsr.sv
module qps_lfsr #(
  parameter int              WIDTH = 3,
  parameter logic [WIDTH-1:0] TAPS = 3'b110,
  parameter logic [WIDTH-1:0] SEED = 3'b001
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  output logic [WIDTH-1:0] state_o
);
  logic [WIDTH-1:0] s_r;
  logic [WIDTH-1:0] s_nxt;
  logic             fb;

  always_comb begin
    fb    = ^(s_r & TAPS);
    s_nxt = s_r;
    if (step_i) s_nxt = {s_r[WIDTH-2:0], fb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s_r <= SEED;
    else        s_r <= s_nxt;
  end

  assign state_o = s_r;
endmodule

// File: rtl/qps_phase_mux.sv
module qps_phase_mux
  import qps_pkg::*;
#(
  parameter int PHASES = NUM_PHASES
) (
  input  logic [PHASES-1:0] taps_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic              out_o
);
  always_comb out_o = taps_i[tap_of(sel_i)];
endmodule

// File: rtl/qpsk_phase_sel.sv
module qpsk_phase_sel
  import qps_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  output logic                  carrier_o,
  output logic [NUM_PHASES-1:0] phase_o,
  output logic [SEL_W-1:0]      sel_o,
  output logic                  dclk_o
);
  logic              tick;
  logic [DATA_W-1:0] data_q;
  logic [SEL_W-1:0]  sel_q;
  logic [SEL_W-1:0]  sel_nxt;

  qps_twist_ring #(.STAGES(RING_STAGES)) u_ring (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .taps_o (phase_o),
    .rise_o (tick)
  );

  qps_lfsr #(.WIDTH(DATA_W), .TAPS(DATA_TAPS), .SEED(DATA_SEED)) u_data (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_i  (tick),
    .state_o (data_q)
  );

  always_comb begin
    sel_nxt = sel_q;
    if (tick) sel_nxt = data_q[SEL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_nxt;
  end

  qps_phase_mux #(.PHASES(NUM_PHASES)) u_mux (
    .taps_i (phase_o),
    .sel_i  (sel_q),
    .out_o  (carrier_o)
  );

  assign sel_o  = sel_q;
  assign dclk_o = phase_o[0];
endmodule

// File: rtl/qps_chk.sv
module qps_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       carrier_o,
  input logic [3:0] phase_o,
  input logic [1:0] sel_o,
  input logic       dclk_o,
  input logic [2:0] data_i
);
  logic exp_car;
  always_comb begin
    case (sel_o)
      2'b00:   exp_car = phase_o[0];
      2'b01:   exp_car = phase_o[2];
      2'b10:   exp_car = phase_o[3];
      default: exp_car = phase_o[1];
    endcase
  end

  // R3
  ring_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (phase_o[1] == $past(phase_o[0]) && phase_o[2] == $past(phase_o[1])
            && phase_o[3] == $past(phase_o[2])));

  // R8
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(phase_o) && $stable(sel_o) && $stable(data_i)));

  // R9
  sel_on_dclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_o) |-> $rose(dclk_o));

  // R6
  sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dclk_o) |-> sel_o == $past(data_i[1:0]));

  // R5
  data_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dclk_o) |-> data_i == {$past(data_i[1:0]), $past(data_i[2]) ^ $past(data_i[1])});

  // R5
  data_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_i != 3'b000);

  // R7
  carrier_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    carrier_o == exp_car);
endmodule

bind qpsk_phase_sel qps_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .carrier_o (carrier_o),
  .phase_o   (phase_o),
  .sel_o     (sel_o),
  .dclk_o    (dclk_o),
  .data_i    (data_q)
);

// File: tb/sim_qpsk_phase_sel.sv
`timescale 1ns/1ps
module sim_qpsk_phase_sel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       carrier_o;
  logic [3:0] phase_o;
  logic [1:0] sel_o;
  logic       dclk_o;

  int checks = 0;
  int failures = 0;
  int cnt = 0;
  logic [2:0] m_data = 3'b001;
  logic [1:0] m_sel = 2'b00;

  always #4 clk = ~clk;

  qpsk_phase_sel u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .carrier_o(carrier_o),
    .phase_o(phase_o), .sel_o(sel_o), .dclk_o(dclk_o)
  );

  function automatic logic tap_ref(input int n, input int k);
    int m = (n + 400 - k) % 4;
    return (m == 1 || m == 2);
  endfunction

  function automatic logic [3:0] taps_ref(input int n);
    logic [3:0] t;
    for (int k = 0; k < 4; k++) t[k] = tap_ref(n, k);
    return t;
  endfunction

  function automatic logic car_ref(input logic [3:0] t, input logic [1:0] s);
    case (s)
      2'b00:   return t[0];
      2'b01:   return t[2];
      2'b10:   return t[3];
      default: return t[1];
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  task automatic check_outputs(input string req);
    logic [3:0] t;
    t = taps_ref(cnt);
    chk(req, "phase_o", 32'(phase_o), 32'(t));
    chk(req, "sel_o", 32'(sel_o), 32'(m_sel));
    chk(req, "carrier_o", 32'(carrier_o), 32'(car_ref(t, m_sel)));
    chk(req, "dclk_o", 32'(dclk_o), 32'(t[0]));
  endtask

  // one clock: drive en at negedge, update model at posedge, return at next negedge
  task automatic cyc(input logic e);
    en = e;
    @(posedge clk);
    if (e) begin
      if (cnt % 4 == 0) begin
        m_sel  = m_data[1:0];
        m_data = {m_data[1:0], m_data[2] ^ m_data[1]};
      end
      cnt++;
    end
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    cnt = 0;
    m_data = 3'b001;
    m_sel = 2'b00;
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    chk("R1", "phase_o in reset", 32'(phase_o), 32'h0000000c);
    do_reset();
    chk("R1", "phase_o after release", 32'(phase_o), 32'h0000000c);
    chk("R1", "sel_o", 32'(sel_o), 32'h0);
    chk("R1", "carrier_o", 32'(carrier_o), 32'h0);
    chk("R1", "dclk_o", 32'(dclk_o), 32'h0);
  endtask

  task automatic t_ring();
    logic [3:0] prev;
    do_reset();
    for (int i = 0; i < 12; i++) begin
      prev = phase_o;
      cyc(1'b1);
      check_outputs("R2");
      chk("R3", "tap lag", 32'(phase_o[3:1]), 32'(prev[2:0]));
      chk("R4", "dclk equals tap0", 32'(dclk_o), 32'(phase_o[0]));
    end
  endtask

  task automatic t_data();
    logic [1:0] rec [0:7];
    logic [1:0] expect_seq [0:6];
    logic [1:0] ps;
    logic       pd;
    expect_seq = '{2'b01, 2'b10, 2'b01, 2'b11, 2'b11, 2'b10, 2'b00};
    do_reset();
    for (int tk = 0; tk < 8; tk++) begin
      for (int c = 0; c < 4; c++) begin
        ps = sel_o;
        pd = dclk_o;
        cyc(1'b1);
        check_outputs("R6");
        if (sel_o != ps)
          chk("R9", "sel change without dclk rise", 32'(dclk_o & ~pd), 32'h1);
        if (c == 0) rec[tk] = sel_o;
      end
    end
    for (int i = 0; i < 7; i++)
      chk("R5", "select sequence", 32'(rec[i]), 32'(expect_seq[i]));
    chk("R5", "period of 7 data steps", 32'(rec[7]), 32'(rec[0]));
  endtask

  task automatic t_mux();
    logic [3:0] seen = 4'h0;
    do_reset();
    for (int i = 0; i < 40; i++) begin
      cyc(1'b1);
      chk("R7", "carrier_o", 32'(carrier_o), 32'(car_ref(taps_ref(cnt), m_sel)));
      seen[sel_o] = 1'b1;
    end
    chk("R7", "all select codes seen", 32'(seen), 32'hf);
  endtask

  task automatic t_enable();
    logic [3:0] snap_p;
    logic [1:0] snap_s;
    logic       snap_c;
    do_reset();
    for (int i = 0; i < 6; i++) cyc(1'b1);
    while (cnt % 4 != 0) cyc(1'b1);
    snap_p = phase_o;
    snap_s = sel_o;
    snap_c = carrier_o;
    for (int i = 0; i < 9; i++) begin
      cyc(1'b0);
      chk("R8", "phase held", 32'(phase_o), 32'(snap_p));
      chk("R8", "sel held", 32'(sel_o), 32'(snap_s));
      chk("R8", "carrier held", 32'(carrier_o), 32'(snap_c));
    end
    for (int i = 0; i < 6; i++) begin
      cyc(1'b1);
      check_outputs("R8");
    end
  endtask

  task automatic t_midrun_reset();
    for (int i = 0; i < 7; i++) cyc(1'b1);
    do_reset();
    check_outputs("R1");
    chk("R1", "phase_o after mid-run reset", 32'(phase_o), 32'h0000000c);
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    failures++;
    $display("FAIL watchdog all-requirements actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset_state();
    t_ring();
    t_data();
    t_mux();
    t_enable();
    t_midrun_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule